// File: doc/BRIEF.md
# GF(4) One-Hot Rail Arithmetic Unit

This block adds or multiplies elements of the four-element Galois field GF(4). The operands and the result travel as one-hot quaternary tokens. Each token is a group of four wires, and exactly one wire is high. Between tokens every wire drops low; this all-low state is the spacer. The scheme is return-to-zero, so each operation costs the same number of wire transitions whatever the data. The unit is a synchronous model of such a balanced datapath. It decodes the incoming groups and checks that they are well formed. It then computes the field result and sends it out again as a one-hot token. The same result also leaves as two dual-rail bits, one for the high digit and one for the low digit. A completion flag shows that a result token is present. An error flag reports malformed input.

A third operation scales a quaternary operand by a binary digit. The binary digit arrives on a dual-rail pair, and the result stays in the quaternary domain without a separate radix converter. A quaternary value v is treated as the digit pair (vH, vL), with v = 2·vH + vL. Field arithmetic uses the reduction x² = x + 1.

Top module: `gf4_rail_alu`

## Requirements
- R1: A quaternary group of four wires carries value k when wire k alone is high (k = 2·vH + vL); all four low is the spacer. A dual-rail pair is `2'b10` for 1, `2'b01` for 0, and `2'b00` for spacer. The result group `y_rails` never has more than one wire high.
- R2: With `op_sel = 2'b00`, the result is the field sum, so each digit of the result is the XOR of the matching operand digits.
- R3: With `op_sel = 2'b01`, the result is the field product. Its low digit is aL·bL ⊕ aH·bH, and its high digit is aH·bL ⊕ aL·bH ⊕ aH·bH.
- R4: With `op_sel = 2'b10`, the result is `a` when the dual-rail digit `s_rails` is 1, and value 0 when it is 0.
- R5: All outputs are registered. A result token appears at the first clock edge at which every operand the operation needs holds a valid token. Until then the outputs stay at spacer, and the error flag stays low.
- R6: The output returns to spacer at the first clock edge after any needed operand returns to spacer.
- R7: `yh_rails` and `yl_rails` carry the high and low digits of the result as dual-rail pairs whenever a token is present. Both pairs are `2'b00` otherwise.
- R8: `done` is high exactly while `y_rails` holds a token.
- R9: The error flag `err` is raised one cycle after either of these input conditions, and the outputs stay at spacer while it is raised.
  - A needed operand group has more than one wire high.
  - The reserved code `op_sel = 2'b11` is applied while `a_rails` or `b_rails` is not spacer.
- R10: Groups the operation does not need have no effect, even when they are malformed. This means `s_rails` under add or multiply, and `b_rails` under scale.
- R11: A synchronous active-high `rst` clears every output to spacer and lowers `done` and `err` at the next edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 2 | 00 add, 01 multiply, 10 scale by binary digit, 11 reserved |
| a_rails | input | 4 | First quaternary operand, one-hot |
| b_rails | input | 4 | Second quaternary operand, one-hot |
| s_rails | input | 2 | Binary scale digit, dual-rail |
| y_rails | output | 4 | Result, one-hot quaternary token or spacer |
| yh_rails | output | 2 | High digit of the result, dual-rail |
| yl_rails | output | 2 | Low digit of the result, dual-rail |
| done | output | 1 | Result token present |
| err | output | 1 | Malformed input seen on the previous edge |

## Verification
A wrong internal decode shows at the ports one cycle later in one of three ways. The result wire can be wrong, more than one result wire can be high, or a token can appear where a spacer belongs. The bench compares the result with a polynomial model of the field for every operand pair and every operation. A mismatch between the one-hot result and its dual-rail copy, or between `done` and the rails, also shows within that single cycle. Stale state would leave a token standing after the inputs go to spacer. The bench therefore checks the spacer after every vector, and after partial arrivals and partial departures of operands.

// File: rtl/gf4_rail_pkg.sv
package gf4_rail_pkg;

  localparam int QUAD_W = 4;
  localparam int DUAL_W = 2;

  typedef enum logic [1:0] {
    OP_ADD   = 2'b00,
    OP_MUL   = 2'b01,
    OP_SCALE = 2'b10,
    OP_RSVD  = 2'b11
  } gf4_op_e;

  // digit pair {high, low}
  typedef logic [1:0] gf4_t;

  function automatic gf4_t gf4_add(gf4_t x, gf4_t y);
    return x ^ y;
  endfunction

  function automatic gf4_t gf4_mul(gf4_t x, gf4_t y);
    gf4_t r;
    r[0] = (x[0] & y[0]) ^ (x[1] & y[1]);
    r[1] = (x[1] & y[0]) ^ (x[0] & y[1]) ^ (x[1] & y[1]);
    return r;
  endfunction

endpackage

// File: rtl/rail_group_rx.sv
// Decodes one one-hot wire group: valid token, multi-hot fault, and index.
module rail_group_rx #(
  parameter int W = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  rails,
  output logic          valid,
  output logic          multi,
  output logic [IW-1:0] idx
);
  int unsigned hot;

  always_comb begin
    hot = 0;
    idx = '0;
    for (int k = 0; k < W; k++) begin
      if (rails[k]) begin
        hot = hot + 1;
        idx = idx | IW'(k);
      end
    end
    valid = (hot == 1);
    multi = (hot > 1);
  end
endmodule

// File: rtl/gf4_op_core.sv
// Field arithmetic on decoded digit pairs.
module gf4_op_core
  import gf4_rail_pkg::*;
(
  input  gf4_op_e op,
  input  gf4_t    a_v,
  input  gf4_t    b_v,
  input  logic    s_v,
  output gf4_t    r_v
);
  always_comb begin
    unique case (op)
      OP_ADD:   r_v = gf4_add(a_v, b_v);
      OP_MUL:   r_v = gf4_mul(a_v, b_v);
      OP_SCALE: r_v = gf4_mul(a_v, {1'b0, s_v});
      default:  r_v = '0;
    endcase
  end
endmodule

// File: rtl/rail_token_tx.sv
// Registers the result as a one-hot token plus its dual-rail digit copy.
module rail_token_tx #(
  parameter int W = 4,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          bad,
  input  logic [IW-1:0] val,
  output logic [W-1:0]  y_rails,
  output logic [IW-1:0][1:0] dig_rails,
  output logic          done,
  output logic          err
);
  logic [W-1:0] y_next;

  for (genvar k = 0; k < W; k++) begin : g_enc
    assign y_next[k] = fire && (val == IW'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_rails   <= '0;
      dig_rails <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      y_rails <= y_next;
      done    <= fire;
      err     <= bad;
      for (int d = 0; d < IW; d++)
        dig_rails[d] <= fire ? (val[d] ? 2'b10 : 2'b01) : 2'b00;
    end
  end
endmodule

// File: rtl/gf4_rail_alu.sv
module gf4_rail_alu
  import gf4_rail_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] op_sel,
  input  logic [3:0] a_rails,
  input  logic [3:0] b_rails,
  input  logic [1:0] s_rails,
  output logic [3:0] y_rails,
  output logic [1:0] yh_rails,
  output logic [1:0] yl_rails,
  output logic       done,
  output logic       err
);
  localparam int NQ = 2;

  gf4_op_e op;
  assign op = gf4_op_e'(op_sel);

  logic [NQ-1:0][QUAD_W-1:0] q_rails;
  logic [NQ-1:0]             q_valid, q_multi;
  gf4_t [NQ-1:0]             q_val;

  assign q_rails[0] = a_rails;
  assign q_rails[1] = b_rails;

  for (genvar i = 0; i < NQ; i++) begin : g_qrx
    rail_group_rx #(.W(QUAD_W)) rx_i (
      .rails (q_rails[i]),
      .valid (q_valid[i]),
      .multi (q_multi[i]),
      .idx   (q_val[i])
    );
  end

  logic s_valid, s_multi, s_val;
  rail_group_rx #(.W(DUAL_W)) srx_i (
    .rails (s_rails),
    .valid (s_valid),
    .multi (s_multi),
    .idx   (s_val)
  );

  logic need_b, need_s, rsvd, bad, fire;
  gf4_t r_v;

  always_comb begin
    need_b = (op == OP_ADD) || (op == OP_MUL);
    need_s = (op == OP_SCALE);
    rsvd   = (op == OP_RSVD);
    bad    = q_multi[0]
           | (need_b & q_multi[1])
           | (need_s & s_multi)
           | (rsvd & ((a_rails != '0) | (b_rails != '0)));
    fire   = !bad && !rsvd && q_valid[0]
           && (!need_b || q_valid[1])
           && (!need_s || s_valid);
  end

  gf4_op_core core_i (
    .op  (op),
    .a_v (q_val[0]),
    .b_v (q_val[1]),
    .s_v (s_val),
    .r_v (r_v)
  );

  logic [1:0][1:0] dig;

  rail_token_tx #(.W(QUAD_W)) tx_i (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .bad       (bad),
    .val       (r_v),
    .y_rails   (y_rails),
    .dig_rails (dig),
    .done      (done),
    .err       (err)
  );

  assign yl_rails = dig[0];
  assign yh_rails = dig[1];
endmodule

// File: rtl/gf4_rail_alu_chk.sv
module gf4_rail_alu_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] a_rails,
  input logic [3:0] y_rails,
  input logic [1:0] yh_rails,
  input logic [1:0] yl_rails,
  input logic       done,
  input logic       err
);
  // R1
  onehot_out_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(y_rails));

  // R8
  done_rails_chk: assert property (@(posedge clk) disable iff (rst)
    done == (y_rails != 4'b0000));

  // R7
  digit_copy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (yh_rails == {y_rails[3] | y_rails[2], y_rails[1] | y_rails[0]}
           && yl_rails == {y_rails[3] | y_rails[1], y_rails[2] | y_rails[0]}));

  // R7
  digit_spacer_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> (yh_rails == 2'b00 && yl_rails == 2'b00));

  // R9
  err_spacer_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (y_rails == 4'b0000));

  // R9
  multi_a_err_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(a_rails) > 1) |=> err);

  // R6
  spacer_return_chk: assert property (@(posedge clk) disable iff (rst)
    (a_rails == 4'b0000) |=> !done);

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (y_rails == 4'b0000 && !done && !err));
endmodule

bind gf4_rail_alu gf4_rail_alu_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .a_rails  (a_rails),
  .y_rails  (y_rails),
  .yh_rails (yh_rails),
  .yl_rails (yl_rails),
  .done     (done),
  .err      (err)
);

// File: tb/gf4_rail_alu_tb_top.sv
module gf4_rail_alu_tb_top;
  localparam int WD_CYCLES = 20000;
  localparam int NVEC = 13;
  // {op[1:0], a[3:0], b[3:0], s[1:0], kind[1:0] (0 spacer,1 token,2 err), v[1:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {2'b00, 4'b0010, 4'b0100, 2'b00, 2'd1, 2'd3}, // R2 1+2=3
    {2'b01, 4'b0100, 4'b0100, 2'b00, 2'd1, 2'd3}, // R3 2*2=3
    {2'b01, 4'b1000, 4'b1000, 2'b00, 2'd1, 2'd2}, // R3 3*3=2
    {2'b01, 4'b0001, 4'b1000, 2'b00, 2'd1, 2'd0}, // R3 0*3=0
    {2'b10, 4'b1000, 4'b0000, 2'b10, 2'd1, 2'd3}, // R4 3*1
    {2'b10, 4'b0100, 4'b1111, 2'b01, 2'd1, 2'd0}, // R10 b ignored
    {2'b00, 4'b0010, 4'b0010, 2'b11, 2'd1, 2'd0}, // R10 s ignored
    {2'b00, 4'b0011, 4'b0100, 2'b00, 2'd2, 2'd0}, // R9 a multi
    {2'b01, 4'b0010, 4'b1100, 2'b00, 2'd2, 2'd0}, // R9 b multi
    {2'b11, 4'b0010, 4'b0000, 2'b00, 2'd2, 2'd0}, // R9 reserved op
    {2'b00, 4'b0010, 4'b0000, 2'b00, 2'd0, 2'd0}, // R5 b missing
    {2'b10, 4'b0010, 4'b0000, 2'b11, 2'd2, 2'd0}, // R9 s multi
    {2'b10, 4'b0010, 4'b0000, 2'b00, 2'd0, 2'd0}  // R5 s missing
  };

  logic clk = 1'b0;
  logic rst;
  logic [1:0] op_sel;
  logic [3:0] a_rails, b_rails;
  logic [1:0] s_rails;
  logic [3:0] y_rails;
  logic [1:0] yh_rails, yl_rails;
  logic done, err;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  gf4_rail_alu dut_i (
    .clk(clk), .rst(rst), .op_sel(op_sel),
    .a_rails(a_rails), .b_rails(b_rails), .s_rails(s_rails),
    .y_rails(y_rails), .yh_rails(yh_rails), .yl_rails(yl_rails),
    .done(done), .err(err)
  );

  function automatic logic [3:0] quad(logic [1:0] v);
    return 4'b0001 << v;
  endfunction

  function automatic logic [1:0] ref_mul(logic [1:0] x, logic [1:0] y);
    logic [2:0] p;
    p = (x[0] ? {1'b0, y} : 3'b000) ^ (x[1] ? {y, 1'b0} : 3'b000);
    if (p[2]) p = p ^ 3'b111;
    return p[1:0];
  endfunction

  task automatic check_out(string req, logic tok, logic [1:0] v, logic e);
    logic [3:0] ey;
    logic [1:0] eh, el;
    ey = tok ? quad(v) : 4'b0000;
    eh = tok ? (v[1] ? 2'b10 : 2'b01) : 2'b00;
    el = tok ? (v[0] ? 2'b10 : 2'b01) : 2'b00;
    checks++;
    if (y_rails !== ey || yh_rails !== eh || yl_rails !== el || done !== tok || err !== e) begin
      failures++;
      $display("FAIL %s y=%b/%b yh=%b/%b yl=%b/%b done=%b/%b err=%b/%b",
               req, y_rails, ey, yh_rails, eh, yl_rails, el, done, tok, err, e);
    end
  endtask

  task automatic drive(logic [1:0] op, logic [3:0] a, logic [3:0] b, logic [1:0] s);
    @(negedge clk);
    op_sel = op; a_rails = a; b_rails = b; s_rails = s;
    @(negedge clk);
  endtask

  task automatic spacer_phase(string req);
    drive(op_sel, 4'b0000, 4'b0000, 2'b00);
    check_out(req, 1'b0, 2'd0, 1'b0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; op_sel = 2'b00; a_rails = '0; b_rails = '0; s_rails = '0;
    repeat (3) @(negedge clk);
    check_out("R11 reset state", 1'b0, 2'd0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][15:14], VEC[i][13:10], VEC[i][9:6], VEC[i][5:4]);
      check_out($sformatf("R1/R5 vector %0d", i), VEC[i][3:2] == 2'd1, VEC[i][1:0],
                VEC[i][3:2] == 2'd2);
      spacer_phase("R6 spacer after vector");
    end

    for (int x = 0; x < 4; x++) begin
      for (int y = 0; y < 4; y++) begin
        drive(2'b00, quad(2'(x)), quad(2'(y)), 2'b00);
        check_out($sformatf("R2 add %0d+%0d", x, y), 1'b1, 2'(x) ^ 2'(y), 1'b0);
        drive(2'b01, quad(2'(x)), quad(2'(y)), 2'b00);
        check_out($sformatf("R3 mul %0d*%0d", x, y), 1'b1, ref_mul(2'(x), 2'(y)), 1'b0);
      end
    end
    spacer_phase("R6 spacer after sweep");

    for (int x = 0; x < 4; x++) begin
      drive(2'b10, quad(2'(x)), 4'b0000, 2'b10);
      check_out("R4 scale by 1", 1'b1, 2'(x), 1'b0);
      drive(2'b10, quad(2'(x)), 4'b0000, 2'b01);
      check_out("R4 scale by 0", 1'b1, 2'd0, 1'b0);
    end
    spacer_phase("R6 spacer after scale");

    // R5: late second operand
    drive(2'b01, quad(2'd2), 4'b0000, 2'b00);
    check_out("R5 waiting for b", 1'b0, 2'd0, 1'b0);
    drive(2'b01, quad(2'd2), quad(2'd3), 2'b00);
    check_out("R5 b arrives", 1'b1, 2'd1, 1'b0);
    // R6: one operand leaves
    drive(2'b01, quad(2'd2), 4'b0000, 2'b00);
    check_out("R6 b returns to spacer", 1'b0, 2'd0, 1'b0);
    // R10: malformed s under multiply
    drive(2'b01, quad(2'd3), quad(2'd2), 2'b11);
    check_out("R10 s ignored under mul", 1'b1, 2'd1, 1'b0);
    // R9: error clears once input is good again
    drive(2'b00, 4'b1111, quad(2'd1), 2'b00);
    check_out("R9 all-hot a", 1'b0, 2'd0, 1'b1);
    drive(2'b00, quad(2'd3), quad(2'd1), 2'b00);
    check_out("R9 recover after error", 1'b1, 2'd2, 1'b0);
    // R11: reset with valid tokens on the inputs
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check_out("R11 reset over token", 1'b0, 2'd0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check_out("R5 token after reset", 1'b1, 2'd2, 1'b0);
    spacer_phase("R6 final spacer");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule